// File: doc/BRIEF.md
# Programmable-Polarity Interrupt Aggregator

This block collects up to sixteen external interrupt request lines into a single combined interrupt output. Each raw input is first brought into the local clock domain through a two-stage synchroniser. It is then converted to an active-true form using a per-line polarity bit. While it is active, it sets a sticky pending bit. Pending bits survive after their source returns to idle. Software clears them by writing zero to the matching bit positions of the request register.

A per-line mask register decides which pending bits may drive the combined output. A mask bit of 0 lets its line through. The mask, polarity and request registers can be reached only after software sets the access-enable bit (bit 2) in the control register. Until then, reads of those registers return zero and writes to them have no effect. The bus side is a plain synchronous register port: address, write strobe, write data, and a read data bus that follows the address in the same cycle. The default line assignments are: line 12 is the network controller, and lines 6, 5, 4 and 3 are expansion-bus interrupts A, B, C and D.

Top module: `pol_irq_agg`

## Requirements
- R1: After reset the control register reads 0, every mask bit is 1, every polarity bit is 0, every pending bit is 0, and `irq_out` is low.
- R2: While control bit 2 is 0, reads at the mask, polarity and request offsets return 0, and writes to those three registers leave them unchanged. The control register itself is always readable and writable, and its low three bits are stored.
- R3: A polarity bit of 0 treats a low input as active; a polarity bit of 1 treats a high input as active. Any cycle in which a line is active sets its pending bit.
- R4: A change on a raw input reaches the pending register on the third rising clock edge after the change, not earlier (two synchroniser flops plus the pending flop).
- R5: A pending bit stays set after its input returns to the inactive level, until it is cleared.
- R6: Writing the request register clears every pending bit whose write-data bit is 0 and leaves pending bits whose write-data bit is 1 unchanged.
- R7: A clear that lands while the line is still active is overridden, and the pending bit stays set.
- R8: `irq_out` is high exactly when some pending bit is set and its mask bit is 0; a mask bit of 1 blocks its line. The output is not gated by the control enable.
- R9: Register offsets decode on address bits [3:2]: control 0x0, mask 0x4, polarity 0x8, request 0xC. Address bits [1:0] are ignored. Register bit i belongs to input line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | LINES (16) | Raw asynchronous request lines |
| bus_addr | input | ADDR_W (4) | Register byte address |
| bus_we | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data for the current address, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The embedded properties assume `irq_in` idles high at reset. Because the polarity bits reset to 0, a low line would be latched as soon as reset ends. The stimulus therefore holds every line high through reset. It changes a polarity bit only while the affected line sits at a level it intends to be active or idle under the new setting. The properties also assume a register write lasts one clock, and the bench drives each write strobe for exactly one cycle. Clears are issued either while the source is still held active, to exercise the override, or at least three edges after release, so that the synchroniser has drained before the clear is expected to take.

// File: rtl/pol_irq_pkg.sv
package pol_irq_pkg;

    localparam int NUM_LINES  = 16;
    localparam int BUS_DATA_W = 16;
    localparam int BUS_ADDR_W = 4;
    localparam int CTRL_W     = 3;
    localparam int ACC_EN_BIT = 2;

    // default line assignment
    localparam int LINE_NET   = 12;
    localparam int LINE_EXP_A = 6;
    localparam int LINE_EXP_B = 5;
    localparam int LINE_EXP_C = 4;
    localparam int LINE_EXP_D = 3;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_POL   = 2'd2,
        SEL_REQ   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ctrl;
        logic mask;
        logic pol;
        logic req;
    } wr_stb_t;

    function automatic reg_sel_e decode_sel(input logic [1:0] word_idx);
        return reg_sel_e'(word_idx);
    endfunction

endpackage

// File: rtl/pol_irq_sync.sv
module pol_irq_sync #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q, stage2_q;

    for (genvar i = 0; i < W; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1_q[i] <= RST_VAL[i];
                stage2_q[i] <= RST_VAL[i];
            end else begin
                stage1_q[i] <= raw_i[i];
                stage2_q[i] <= stage1_q[i];
            end
        end
    end

    assign sync_o = stage2_q;

    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)              age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R4: output lags input by exactly two edges
    p_two_stage_r4: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> (sync_o == $past(raw_i, 2)));

endmodule

// File: rtl/pol_irq_pend.sv
module pol_irq_pend #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] pol_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_keep_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] active;
    logic [W-1:0] pend_q;

    for (genvar i = 0; i < W; i++) begin : g_line
        assign active[i] = pol_i[i] ? sync_i[i] : ~sync_i[i];

        always_ff @(posedge clk) begin
            if (rst)
                pend_q[i] <= 1'b0;
            else if (active[i])
                pend_q[i] <= 1'b1;
            else if (clr_we_i && !clr_keep_i[i])
                pend_q[i] <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    logic past_ok_q;
    always_ff @(posedge clk) begin
        if (rst) past_ok_q <= 1'b0;
        else     past_ok_q <= 1'b1;
    end

    // R3 / R7: an active line always ends up pending, clear or not
    p_active_sets_r3: assert property (@(posedge clk) disable iff (rst)
        past_ok_q |-> ((pend_q & $past(active)) == $past(active)));

    // R5: without a clear write no pending bit falls
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && !$past(clr_we_i)) |-> (($past(pend_q) & ~pend_q) == '0));

    // R6: zero bits of a clear drop pending unless the line was active
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && $past(clr_we_i)) |->
            ((pend_q & ~$past(clr_keep_i) & ~$past(active)) == '0));

endmodule

// File: rtl/pol_irq_regs.sv
module pol_irq_regs
    import pol_irq_pkg::*;
#(
    parameter int LINES  = NUM_LINES,
    parameter int DATA_W = BUS_DATA_W,
    parameter int ADDR_W = BUS_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LINES-1:0]  pend_i,
    output logic [LINES-1:0]  mask_o,
    output logic [LINES-1:0]  pol_o,
    output logic              clr_we_o,
    output logic [LINES-1:0]  clr_keep_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_W = DATA_W - LINES;
    localparam int CPAD_W = DATA_W - CTRL_W;

    reg_sel_e          sel;
    wr_stb_t           stb;
    logic [CTRL_W-1:0] ctrl_q;
    logic [LINES-1:0]  mask_q, pol_q;
    logic              acc_en;
    logic              unused_addr_lo;

    assign sel            = decode_sel(addr_i[3:2]);
    assign acc_en         = ctrl_q[ACC_EN_BIT];
    assign unused_addr_lo = ^addr_i[1:0];

    always_comb begin
        stb = '0;
        if (we_i) begin
            case (sel)
                SEL_CTRL: stb.ctrl = 1'b1;
                SEL_MASK: stb.mask = acc_en;
                SEL_POL:  stb.pol  = acc_en;
                SEL_REQ:  stb.req  = acc_en;
                default:  stb      = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '1;
            pol_q  <= '0;
        end else begin
            if (stb.ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
            if (stb.mask) mask_q <= wdata_i[LINES-1:0];
            if (stb.pol)  pol_q  <= wdata_i[LINES-1:0];
        end
    end

    assign mask_o     = mask_q;
    assign pol_o      = pol_q;
    assign clr_we_o   = stb.req;
    assign clr_keep_o = wdata_i[LINES-1:0];

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_CTRL: rdata_o = {{CPAD_W{1'b0}}, ctrl_q};
            SEL_MASK: if (acc_en) rdata_o = {{PAD_W{1'b0}}, mask_q};
            SEL_POL:  if (acc_en) rdata_o = {{PAD_W{1'b0}}, pol_q};
            SEL_REQ:  if (acc_en) rdata_o = {{PAD_W{1'b0}}, pend_i};
            default:  rdata_o = '0;
        endcase
    end

    logic past_ok_q;
    always_ff @(posedge clk) begin
        if (rst) past_ok_q <= 1'b0;
        else     past_ok_q <= 1'b1;
    end

    // R2: with access disabled the gated registers hold
    p_gate_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && !$past(acc_en)) |-> ($stable(mask_q) && $stable(pol_q)));

    // R2: no clear reaches the pending logic while disabled
    p_gate_clr_r2: assert property (@(posedge clk) disable iff (rst)
        !acc_en |-> !clr_we_o);

endmodule

// File: rtl/pol_irq_agg.sv
module pol_irq_agg
    import pol_irq_pkg::*;
#(
    parameter int LINES  = NUM_LINES,
    parameter int DATA_W = BUS_DATA_W,
    parameter int ADDR_W = BUS_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  irq_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    logic [LINES-1:0] sync_lines, pol, mask, pend, clr_keep;
    logic             clr_we;

    pol_irq_sync #(.W(LINES), .RST_VAL({LINES{1'b1}})) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (irq_in),
        .sync_o (sync_lines)
    );

    pol_irq_pend #(.W(LINES)) u_pend (
        .clk        (clk),
        .rst        (rst),
        .sync_i     (sync_lines),
        .pol_i      (pol),
        .clr_we_i   (clr_we),
        .clr_keep_i (clr_keep),
        .pend_o     (pend)
    );

    pol_irq_regs #(.LINES(LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (bus_addr),
        .we_i       (bus_we),
        .wdata_i    (bus_wdata),
        .pend_i     (pend),
        .mask_o     (mask),
        .pol_o      (pol),
        .clr_we_o   (clr_we),
        .clr_keep_o (clr_keep),
        .rdata_o    (bus_rdata)
    );

    assign irq_out = |(pend & ~mask);

    // R8: fully masked means silent
    p_all_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (&mask) |-> !irq_out);

    // R8: nothing pending means silent
    p_none_pending_r8: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> !irq_out);

endmodule

// File: tb/pol_irq_agg_bench.sv
module pol_irq_agg_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_CTRL = 4'h0, A_MASK = 4'h4, A_POL = 4'h8, A_REQ = 4'hC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_in = 16'hFFFF;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] rd;
        logic        irq;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    event smp;

    always #(CLK_PERIOD/2) clk = ~clk;

    pol_irq_agg u_pol_irq_agg (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input logic ei, input string t);
        exp_t it;
        @(negedge clk);
        bus_addr = a;
        #1;
        it.rd = e; it.irq = ei; it.tag = t;
        exp_q.push_back(it);
        -> smp;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            exp_t it;
            @smp;
            while (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                checks++;
                if (bus_rdata !== it.rd || irq_out !== it.irq) begin
                    fails++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             it.tag, bus_rdata, irq_out, it.rd, it.irq);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        rd(A_CTRL, 16'h0000, 1'b0, "R1 control after reset");
        rd(A_MASK, 16'h0000, 1'b0, "R2 mask hidden while disabled");
        wr(A_MASK, 16'h0000);
        wr(A_CTRL, 16'h0004);
        rd(A_CTRL, 16'h0004, 1'b0, "R2 control readback");
        rd(A_MASK, 16'hFFFF, 1'b0, "R1 R2 mask reset, disabled write ignored");
        rd(A_POL,  16'h0000, 1'b0, "R1 polarity reset");
        rd(A_REQ,  16'h0000, 1'b0, "R1 pending reset");

        // R4 latency, R3 active-low on line 3
        irq_in[3] = 1'b0;
        rd(A_REQ, 16'h0000, 1'b0, "R4 one edge");
        rd(A_REQ, 16'h0000, 1'b0, "R4 two edges");
        rd(A_REQ, 16'h0008, 1'b0, "R4 R3 three edges, R8 masked");
        irq_in[3] = 1'b1;
        idle(4);
        rd(A_REQ, 16'h0008, 1'b0, "R5 sticky after release");

        wr(A_MASK, 16'hFFF7);
        rd(A_MASK, 16'hFFF7, 1'b1, "R8 unmasked line drives irq");
        wr(A_MASK, 16'hFFFF);
        rd(A_REQ, 16'h0008, 1'b0, "R8 mask 1 blocks");

        wr(A_REQ, 16'hFFFF);
        rd(A_REQ, 16'h0008, 1'b0, "R6 write one keeps");
        wr(A_REQ, 16'hFFF7);
        rd(A_REQ, 16'h0000, 1'b0, "R6 write zero clears");

        // R7 clear overridden while active
        irq_in[3] = 1'b0;
        idle(3);
        wr(A_REQ, 16'h0000);
        rd(A_REQ, 16'h0008, 1'b0, "R7 clear while active");
        irq_in[3] = 1'b1;
        idle(3);
        wr(A_REQ, 16'hFFF7);
        rd(A_REQ, 16'h0000, 1'b0, "R6 clear after release");

        // R3 active-high on line 4
        wr(A_POL, 16'h0010);
        idle(1);
        rd(A_REQ, 16'h0010, 1'b0, "R3 high input active at polarity 1");
        irq_in[4] = 1'b0;
        idle(3);
        wr(A_REQ, 16'hFFEF);
        rd(A_REQ, 16'h0000, 1'b0, "R3 low input idle at polarity 1");
        irq_in[4] = 1'b1;
        idle(3);
        rd(A_POL, 16'h0010, 1'b0, "R3 polarity readback");

        // several lines at once, R9 line numbering
        irq_in[12] = 1'b0;
        irq_in[6]  = 1'b0;
        idle(3);
        rd(A_REQ, 16'h1050, 1'b0, "R9 lines 12 6 4 map to bits");
        wr(A_MASK, 16'hEFFF);
        rd(A_MASK, 16'hEFFF, 1'b1, "R8 line 12 unmasked");

        irq_in[12] = 1'b1;
        irq_in[6]  = 1'b1;
        irq_in[4]  = 1'b0;
        idle(3);
        wr(A_CTRL, 16'h0000);
        rd(A_REQ,  16'h0000, 1'b1, "R2 request hidden, R8 irq ungated");
        rd(A_POL,  16'h0000, 1'b1, "R2 polarity hidden");
        wr(A_REQ,  16'h0000);
        wr(A_POL,  16'h0000);
        wr(A_MASK, 16'hFFFF);
        wr(A_CTRL, 16'h0004);
        rd(A_REQ,  16'h1050, 1'b1, "R2 disabled clear ignored");
        rd(A_POL,  16'h0010, 1'b1, "R2 disabled polarity write ignored");
        rd(A_MASK, 16'hEFFF, 1'b1, "R2 disabled mask write ignored");
        rd(4'hD,   16'h1050, 1'b1, "R9 low address bits ignored");
        rd(4'h9,   16'h0010, 1'b1, "R9 polarity at offset 8");
        wr(A_REQ,  16'h0000);
        rd(A_REQ,  16'h0000, 1'b0, "R6 clear all");

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule